// File: doc/BRIEF.md
# Run-Length Bit String Scanner

This block measures one run of identical bits inside a bit string held in byte-wide memory. It is the front half of a run-length compressor: software or a sequencer hands it a byte base address, a starting bit offset, an inclusive last bit offset, a ceiling on the run length and a polarity. The scanner then reads bytes through a request/valid read port and counts consecutive bits that equal the polarity. It stops on the first bit of the other value, at the end of the allowed offset range, or when the count reaches its ceiling.

When it finishes, the block pulses `done` for one cycle. In that cycle it presents the run length, the bit offset where scanning stopped and two flags. A stop on an opposite bit leaves the offset pointing at that bit, so a scan of the other polarity can start from the returned offset at once. All inputs are sampled when a scan is accepted and are not written back or altered.

Top module: `rlsScanner`

## Requirements
- R1: With `polarity` = 0 the block counts clear bits and ends the run at the first set bit.
- R2: With `polarity` = 1 the block counts set bits and ends the run at the first clear bit.
- R3: Bit offset n is bit n mod 8 (bit 0 = least significant) of the byte at `baseAddr` + floor(n/8), and the scan moves to higher offsets.
- R4: Offsets up to and including `maxOffset` are scanned. A run that passes `maxOffset` without meeting the run limit ends with `endOffset` = `maxOffset`+1, `flagF` = polarity and `flagL` = 0.
- R5: When the count equals `maxRun` (including `maxRun` = 0), the scan ends with `runLen` = `maxRun`, `endOffset` = start + `maxRun`, `flagF` = polarity and `flagL` = 1.
- R6: A stop on an opposite bit gives `endOffset` = offset of that bit, `runLen` = number of bits counted, `flagF` = inverse of polarity and `flagL` = 1.
- R7: If `startOffset` > `maxOffset`, no byte is read and the result is `runLen` = 0, `endOffset` = `startOffset`, `flagF` = polarity and `flagL` = 0.
- R8: If the run limit and the offset limit are reached at the same step, the run limit wins and `flagL` = 1.
- R9: Exactly one read is issued for each byte that holds an examined bit, and reads occur only while `busy` is high.
- R10: Once `rdReq` is raised, it stays high with `rdAddr` unchanged until the cycle in which `rdValid` is high.
- R11: `start` is accepted only when `busy` is low. `done` is a single-cycle pulse with `busy` low. Changes to `start` or to the operand inputs while busy do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (accepted when idle) |
| baseAddr | input | ADDR_W | Byte base address of the bit string |
| startOffset | input | OFF_W | First bit offset to examine |
| maxOffset | input | OFF_W | Last bit offset that may be examined |
| maxRun | input | RUN_W | Run length ceiling |
| polarity | input | 1 | Bit value being counted |
| rdReq | output | 1 | Memory read request |
| rdAddr | output | ADDR_W | Memory byte address |
| rdData | input | 8 | Memory read data |
| rdValid | input | 1 | Read data valid; completes the request |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle result strobe |
| runLen | output | RUN_W | Counted run length |
| endOffset | output | OFF_W+1 | Bit offset where scanning stopped |
| flagF | output | 1 | Value of the last bit evaluated, or polarity if none |
| flagL | output | 1 | Opposite bit found or run limit reached |

## Verification
The run-length ceiling and the end of the offset range can be reached at the same step. That collision decides `flagL`. The bench provokes it by choosing `maxRun` equal to `maxOffset` − `startOffset` + 1 over a stretch of memory with no opposite bit. It expects `flagL` = 1 with `endOffset` = `maxOffset`+1, and it checks nearby cases where only one of the two limits is reached. A second overlap happens when the starting offset is already past the end and `maxRun` is 0. The skip rule wins there, and the bench expects `flagL` = 0 with no reads.

// File: rtl/rlsPkg.sv
package rlsPkg;

  // How a scan ended; selects the flag values latched at finish.
  typedef enum logic [1:0] {
    FIN_OFFSET = 2'd0,
    FIN_RUN    = 2'd1,
    FIN_FOUND  = 2'd2,
    FIN_SKIP   = 2'd3
  } finKind_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic     load;
    logic     capture;
    logic     advance;
    logic     finish;
    finKind_t kind;
  } dpCtl_t;

  // Conditions reported by the datapath to the sequencer.
  typedef struct packed {
    logic pastEnd;
    logic runFull;
    logic bitMiss;
    logic byteLoaded;
  } dpStat_t;

endpackage

// File: rtl/rlsCtrl.sv
module rlsCtrl
  import rlsPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    rdValid,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    rdReq,
  output logic    busy
);

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CHECK = 2'd1,
    S_FETCH = 2'd2,
    S_EVAL  = 2'd3
  } state_t;

  state_t stateQ, stateD;
  logic   firstQ;

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    rdReq  = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        if (start) begin
          ctl.load = 1'b1;
          stateD   = S_CHECK;
        end
      end
      S_CHECK: begin
        if (firstQ && stat.pastEnd) begin
          ctl.finish = 1'b1;
          ctl.kind   = FIN_SKIP;
          stateD     = S_IDLE;
        end else if (stat.runFull) begin
          ctl.finish = 1'b1;
          ctl.kind   = FIN_RUN;
          stateD     = S_IDLE;
        end else if (stat.pastEnd) begin
          ctl.finish = 1'b1;
          ctl.kind   = FIN_OFFSET;
          stateD     = S_IDLE;
        end else if (!stat.byteLoaded) begin
          stateD = S_FETCH;
        end else begin
          stateD = S_EVAL;
        end
      end
      S_FETCH: begin
        rdReq = 1'b1;
        if (rdValid) begin
          ctl.capture = 1'b1;
          stateD      = S_EVAL;
        end
      end
      S_EVAL: begin
        if (stat.bitMiss) begin
          ctl.finish = 1'b1;
          ctl.kind   = FIN_FOUND;
          stateD     = S_IDLE;
        end else begin
          ctl.advance = 1'b1;
          stateD      = S_CHECK;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      firstQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (ctl.load)
        firstQ <= 1'b1;
      else if (stateQ == S_CHECK)
        firstQ <= 1'b0;
    end
  end

  assign busy = (stateQ != S_IDLE);

endmodule

// File: rtl/rlsDatapath.sv
module rlsDatapath
  import rlsPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 12,
  parameter int RUN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [OFF_W-1:0]  startOffset,
  input  logic [OFF_W-1:0]  maxOffset,
  input  logic [RUN_W-1:0]  maxRun,
  input  logic              polarity,
  input  logic [7:0]        rdData,
  output dpStat_t           stat,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              done,
  output logic [RUN_W-1:0]  runLen,
  output logic [OFF_W:0]    endOffset,
  output logic              flagF,
  output logic              flagL
);

  localparam int CUR_W  = OFF_W + 1;
  localparam int BIT_W  = 3;
  localparam int IDX_W  = CUR_W - BIT_W;

  // Operands captured at start
  logic [ADDR_W-1:0] baseQ;
  logic [CUR_W-1:0]  maxOffQ;
  logic [RUN_W-1:0]  maxRunQ;
  logic              polQ;

  // Scan state
  logic [CUR_W-1:0]  curQ;
  logic [RUN_W-1:0]  cntQ;
  logic [7:0]        byteQ;
  logic              byteLoadedQ;

  // Results
  logic [RUN_W-1:0]  runLenQ;
  logic [CUR_W-1:0]  endOffQ;
  logic              flagFQ, flagLQ, doneQ;

  logic [IDX_W-1:0]  byteIdx;
  logic [BIT_W-1:0]  bitSel;
  logic              curBit;
  logic              lastInByte;

  assign byteIdx    = curQ[CUR_W-1:BIT_W];
  assign bitSel     = curQ[BIT_W-1:0];
  assign curBit     = byteQ[bitSel];
  assign lastInByte = (bitSel == {BIT_W{1'b1}});
  assign rdAddr     = baseQ + ADDR_W'(byteIdx);

  assign stat.pastEnd    = (curQ > maxOffQ);
  assign stat.runFull    = (cntQ == maxRunQ);
  assign stat.bitMiss    = (curBit != polQ);
  assign stat.byteLoaded = byteLoadedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ       <= '0;
      maxOffQ     <= '0;
      maxRunQ     <= '0;
      polQ        <= 1'b0;
      curQ        <= '0;
      cntQ        <= '0;
      byteQ       <= '0;
      byteLoadedQ <= 1'b0;
    end else begin
      if (ctl.load) begin
        baseQ       <= baseAddr;
        maxOffQ     <= {1'b0, maxOffset};
        maxRunQ     <= maxRun;
        polQ        <= polarity;
        curQ        <= {1'b0, startOffset};
        cntQ        <= '0;
        byteLoadedQ <= 1'b0;
      end else if (ctl.capture) begin
        byteQ       <= rdData;
        byteLoadedQ <= 1'b1;
      end else if (ctl.advance) begin
        curQ <= curQ + CUR_W'(1);
        cntQ <= cntQ + RUN_W'(1);
        if (lastInByte)
          byteLoadedQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLenQ <= '0;
      endOffQ <= '0;
      flagFQ  <= 1'b0;
      flagLQ  <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= ctl.finish;
      if (ctl.finish) begin
        runLenQ <= cntQ;
        endOffQ <= curQ;
        flagFQ  <= (ctl.kind == FIN_FOUND) ? ~polQ : polQ;
        flagLQ  <= (ctl.kind == FIN_FOUND) || (ctl.kind == FIN_RUN);
      end
    end
  end

  assign done      = doneQ;
  assign runLen    = runLenQ;
  assign endOffset = endOffQ;
  assign flagF     = flagFQ;
  assign flagL     = flagLQ;

endmodule

// File: rtl/rlsScanner.sv
module rlsScanner
  import rlsPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 12,
  parameter int RUN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [OFF_W-1:0]  startOffset,
  input  logic [OFF_W-1:0]  maxOffset,
  input  logic [RUN_W-1:0]  maxRun,
  input  logic              polarity,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  input  logic              rdValid,
  output logic              busy,
  output logic              done,
  output logic [RUN_W-1:0]  runLen,
  output logic [OFF_W:0]    endOffset,
  output logic              flagF,
  output logic              flagL
);

  dpCtl_t  ctl;
  dpStat_t stat;

  rlsCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .rdValid (rdValid),
    .stat    (stat),
    .ctl     (ctl),
    .rdReq   (rdReq),
    .busy    (busy)
  );

  rlsDatapath #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .RUN_W  (RUN_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .baseAddr    (baseAddr),
    .startOffset (startOffset),
    .maxOffset   (maxOffset),
    .maxRun      (maxRun),
    .polarity    (polarity),
    .rdData      (rdData),
    .stat        (stat),
    .rdAddr      (rdAddr),
    .done        (done),
    .runLen      (runLen),
    .endOffset   (endOffset),
    .flagF       (flagF),
    .flagL       (flagL)
  );

endmodule

// File: rtl/rlsScannerChk.sv
module rlsScannerChk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdValid,
  input logic              busy,
  input logic              done
);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R11
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> (rdReq && $stable(rdAddr)));

  // R9
  req_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> busy);

endmodule

bind rlsScanner rlsScannerChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .rdReq   (rdReq),
  .rdAddr  (rdAddr),
  .rdValid (rdValid),
  .busy    (busy),
  .done    (done)
);

// File: tb/sim_rlsScanner.sv
`timescale 1ns/1ps
module sim_rlsScanner;

  localparam int ADDR_W = 16;
  localparam int OFF_W  = 12;
  localparam int RUN_W  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic [OFF_W-1:0]  startOffset = '0;
  logic [OFF_W-1:0]  maxOffset = '0;
  logic [RUN_W-1:0]  maxRun = '0;
  logic              polarity = 1'b0;
  logic              rdReq;
  logic [ADDR_W-1:0] rdAddr;
  logic [7:0]        rdData;
  logic              rdValid;
  logic              busy, done, flagF, flagL;
  logic [RUN_W-1:0]  runLen;
  logic [OFF_W:0]    endOffset;

  always #10 clk = ~clk;

  rlsScanner #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .RUN_W(RUN_W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .startOffset(startOffset), .maxOffset(maxOffset), .maxRun(maxRun),
    .polarity(polarity), .rdReq(rdReq), .rdAddr(rdAddr), .rdData(rdData),
    .rdValid(rdValid), .busy(busy), .done(done), .runLen(runLen),
    .endOffset(endOffset), .flagF(flagF), .flagL(flagL)
  );

  // Memory model: 64 bytes, answers one cycle after a request
  logic [7:0] mem [64];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdReq && !rdValid;
      rdData  <= mem[rdAddr[5:0]];
    end
  end

  int readCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readCnt <= 0;
    else if (start && !busy) readCnt <= 0;
    else if (rdReq && rdValid) readCnt <= readCnt + 1;
  end

  typedef struct {
    int    run;
    int    off;
    bit    f;
    bit    l;
    int    reads;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int failures = 0;

  function automatic expItem_t model(int base, int st, int mx, int mr, bit pol, string tag);
    expItem_t e;
    int cur, cnt, loaded;
    bit b;
    e.tag = tag; e.reads = 0;
    if (st > mx) begin
      e.run = 0; e.off = st; e.f = pol; e.l = 0;
      return e;
    end
    cur = st; cnt = 0; loaded = -1;
    for (int guard = 0; guard < 5000; guard++) begin
      if (cnt == mr) begin
        e.run = cnt; e.off = cur; e.f = pol; e.l = 1; return e;
      end
      if (cur > mx) begin
        e.run = cnt; e.off = cur; e.f = pol; e.l = 0; return e;
      end
      if ((cur >> 3) != loaded) begin
        loaded = cur >> 3;
        e.reads++;
      end
      b = mem[(base + (cur >> 3)) & 63][cur & 7];
      if (b != pol) begin
        e.run = cnt; e.off = cur; e.f = ~pol; e.l = 1; return e;
      end
      cur++; cnt++;
    end
    e.run = -1; e.off = -1; e.f = 0; e.l = 0;
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: pushes the expected item then runs one scan
  task automatic runScan(int base, int st, int mx, int mr, bit pol, string tag, bit disturb);
    expQ.push_back(model(base, st, mx, mr, pol, tag));
    @(negedge clk);
    baseAddr = ADDR_W'(base); startOffset = OFF_W'(st); maxOffset = OFF_W'(mx);
    maxRun = RUN_W'(mr); polarity = pol; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      // R11: operand changes and a second start while busy have no effect
      baseAddr = 16'h0033; startOffset = 12'd7; maxOffset = 12'd1;
      maxRun = 8'd1; polarity = ~pol; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares each result with the head of the queue
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R11", "unexpected done", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(int'(runLen) == e.run, e.tag, "runLen", int'(runLen), e.run);
        check(int'(endOffset) == e.off, e.tag, "endOffset", int'(endOffset), e.off);
        check(flagF == e.f, e.tag, "flagF", int'(flagF), int'(e.f));
        check(flagL == e.l, e.tag, "flagL", int'(flagL), int'(e.l));
        check(readCnt == e.reads, e.tag, "reads (R9)", readCnt, e.reads);
      end
    end
  end

  bit finished = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 29) ^ 8'h5A;
    mem[10] = 8'hFF; mem[11] = 8'hFF; mem[12] = 8'h0F;
    mem[20] = 8'h00; mem[21] = 8'h00; mem[22] = 8'hE0;
    mem[30] = 8'b0000_1000;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(!busy && !done && !rdReq, "R11", "idle after reset", int'({busy, done, rdReq}), 0);

    runScan(20, 0, 100, 200, 1'b0, "R1", 1'b0);   // clear run across three bytes
    runScan(10, 3, 100, 200, 1'b1, "R2", 1'b0);   // set run from mid-byte
    runScan(30, 0, 100, 200, 1'b0, "R3", 1'b0);   // bit 3 of byte 30
    runScan(29, 8, 100, 200, 1'b0, "R3", 1'b0);   // same byte reached via offset
    runScan(20, 2, 10, 200, 1'b0, "R4", 1'b0);    // offset limit
    runScan(10, 0, 100, 6, 1'b1, "R5", 1'b0);     // run limit
    runScan(10, 0, 100, 0, 1'b1, "R5", 1'b0);     // zero run limit
    runScan(20, 0, 100, 200, 1'b1, "R6", 1'b0);   // first bit is opposite
    runScan(10, 16, 100, 200, 1'b1, "R6", 1'b0);  // ends at 20 for next scan
    runScan(10, 20, 100, 200, 1'b0, "R6", 1'b0);  // opposite polarity resumes
    runScan(40, 50, 40, 9, 1'b1, "R7", 1'b0);     // skip, polarity 1
    runScan(40, 50, 40, 0, 1'b0, "R7", 1'b0);     // skip wins over zero limit
    runScan(20, 4, 11, 8, 1'b0, "R8", 1'b0);      // both limits at one step
    runScan(20, 4, 11, 9, 1'b0, "R8", 1'b0);      // offset limit only
    runScan(20, 4, 12, 8, 1'b0, "R8", 1'b0);      // run limit only
    runScan(10, 0, 60, 200, 1'b1, "R11", 1'b1);   // disturbed while busy
    runScan(20, 1, 30, 200, 1'b0, "R11", 1'b1);
    for (int k = 0; k < 16; k++) begin
      runScan(k * 3, (k * 5) % 24, (k * 5) % 24 + (k * 7) % 30,
              (k % 4 == 0) ? 4 : 40, k[0], "R9", 1'b0);
    end
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R11", "pending results", expQ.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule